// File: doc/BRIEF.md
# Glitch-Tolerant Strobe-Qualified Bus Slave Bridge

This block sits between an asynchronous, strobe-timed backplane bus and a simple synchronous register port of a local peripheral, for example the controller of a removable flash card that holds configuration images. The active-low data strobe, the write line, the address, the write data and an address-match flag all come in through a synchronizer onto the local clock. An access to the peripheral starts only once the strobe has been seen low, with the address matching, for a programmable number of consecutive samples. Shorter strobe pulses are dropped. A pulse that shows up just after a completed write therefore cannot produce a spurious read.

A read holds the peripheral read strobe for a fixed number of clocks and then captures the returned word. It does not wait for the bus strobe to go away. The captured word is driven with an output enable, and the bus acknowledge is raised, until the bus strobe is released. A write hands the captured address and data to the peripheral with a one-clock write pulse. After the acknowledge drops, the block needs a run of high strobe samples before it will accept anything new. Each bus cycle therefore causes at most one peripheral access.

Top module: `vme_strobe_bridge`

## Requirements
- R1: After a synchronous active-low reset, `bus_ack`, `bus_rdata_oe`, `per_rd` and `per_wr` are all low.
- R2: A peripheral access starts only after `QUAL_CYC` consecutive synchronized samples (default 10, i.e. 50 ns at 200 MHz) with `bus_strb_n` low and `bus_sel` high. A strobe held low for `QUAL_CYC-1` clocks produces no access, and one held low for exactly `QUAL_CYC` clocks produces one.
- R3: A read drives `per_rd` high for exactly `RD_CYC` consecutive clocks, even when the bus strobe is released before the read completes.
- R4: The word on `per_rdata` in the last `per_rd` clock is captured. It appears on `bus_rdata` with `bus_rdata_oe` high and stays stable while the acknowledge is held.
- R5: A write raises `per_wr` for exactly one clock, with `per_addr` and `per_wdata` equal to the address and data presented on the bus.
- R6: `bus_ack` is high while an access is being acknowledged. It falls at the third rising edge after `bus_strb_n` goes high: two synchronizer edges plus one state update.
- R7: One bus cycle produces at most one peripheral access, however long the strobe is held low. After the acknowledge drops, `REL_CYC` consecutive high strobe samples are needed before a new qualification can start.
- R8: A strobe pulse shorter than `QUAL_CYC` clocks that follows a completed write produces no read and no write.
- R9: While `bus_sel` is low, a strobe of any length produces no access and no acknowledge.
- R10: `bus_wr_n` as sampled at qualification picks the direction: 0 selects a write and 1 selects a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_strb_n | input | 1 | Asynchronous active-low data strobe |
| bus_wr_n | input | 1 | Asynchronous direction line, 0 = write |
| bus_sel | input | 1 | Asynchronous address-match flag, 1 = this slave |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Latched read data |
| bus_rdata_oe | output | 1 | Read data output enable |
| bus_ack | output | 1 | Transfer acknowledge, active high |
| per_addr | output | AW | Peripheral register address |
| per_wdata | output | DW | Peripheral write data |
| per_wr | output | 1 | Peripheral write pulse |
| per_rd | output | 1 | Peripheral read strobe |
| per_rdata | input | DW | Peripheral read data |

## Verification
The assertions take three things for granted. Address, data, direction and match flag stay steady from the fall of the strobe until the acknowledge has dropped. The peripheral returns stable data while its read strobe is high. After an accepted cycle, the strobe stays high long enough for the read and the release window to finish before the next fall. The random stimulus draws strobe widths on both sides of the qualification threshold and holds the bus fields constant during each pulse. It leaves a gap of at least `RD_CYC+REL_CYC+4` clocks after each pulse, except in the directed case that fires a deliberate short pulse into the release window of a write.

// File: rtl/vsb_pkg.sv
// Package: shared types of the strobe-qualified bus bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package vsb_pkg;

    // Sequencer states: idle, counting strobe samples, reading, writing,
    // acknowledging, and waiting for a clean strobe release.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_QUAL    = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RELEASE = 3'd5
    } vsb_state_e;

endpackage

// File: rtl/vsb_sync.sv
// Module: vsb_sync
// A multi-stage flop chain that brings a vector of asynchronous bus lines
// into the local clock domain. Each bit has its own chain.
// Assumes: multi-bit fields are held stable by the bus master while they are
// used, so skew between bits settles before the strobe qualifies.
module vsb_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first stage: capture the raw asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // later stages: pass the value one flop further
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/vsb_qualify.sv
// Module: vsb_qualify
// Counts consecutive synchronized samples in which the strobe is low and the
// address matches. Raises done combinationally on the sample that completes
// QUAL_CYC of them. Any break in the run clears the count.
// Assumes: arm is high only while the sequencer is free to start an access.
module vsb_qualify #(
    parameter int QUAL_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic low,
    output logic done
);

    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    logic [CW-1:0] cnt;

    // done fires on the sample that completes the required run
    assign done = arm && low && (cnt == LAST);

    // run-length counter of qualifying samples
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (!arm || !low || done) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R2: a sample without a low, matching strobe empties the count
    a_r2_run_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !low |=> (cnt == '0));

    // R2: done is only reached once the count has climbed to its last value
    a_r2_done_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (QUAL_CYC > 1 && done) |-> $past(arm && low));

endmodule

// File: rtl/vsb_seq.sv
// Module: vsb_seq
// Access sequencer. It starts a read or a write when qualification completes,
// times a fixed-length read, holds the acknowledge and the read data until
// the strobe is released, and then requires a run of high strobe samples
// before it re-arms.
// Assumes: inputs are already synchronized. addr_s and wdata_s are stable
// when qual_done fires. per_rdata is valid in the last read clock.
module vsb_seq
    import vsb_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int RD_CYC  = 4,
    parameter int REL_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_low,
    input  logic          wr_sel,
    input  logic          qual_done,
    input  logic          qual_low,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] wdata_s,
    input  logic [DW-1:0] per_rdata,
    output logic          arm,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic          per_wr,
    output logic          per_rd,
    output logic          bus_ack,
    output logic          bus_rdata_oe,
    output logic [DW-1:0] bus_rdata
);

    localparam int RW = $clog2(RD_CYC + 1);
    localparam int LW = $clog2(REL_CYC + 1);
    localparam logic [RW-1:0] RD_LAST  = RW'(RD_CYC - 1);
    localparam logic [LW-1:0] REL_LAST = LW'(REL_CYC - 1);

    vsb_state_e     state;
    logic [RW-1:0]  rcnt;
    logic [LW-1:0]  relcnt;
    logic           is_wr;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;

    // qualification may run only while no access is under way
    assign arm = (state == ST_IDLE) || (state == ST_QUAL);

    // state sequencing and access timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rcnt   <= '0;
            relcnt <= '0;
            is_wr  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_QUAL: begin
                    if (qual_done) begin
                        is_wr <= wr_sel;
                        rcnt  <= '0;
                        state <= wr_sel ? ST_WRITE : ST_READ;
                    end else if (qual_low) begin
                        state <= ST_QUAL;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (rcnt == RD_LAST) state <= ST_HOLD;
                    else                 rcnt  <= rcnt + 1'b1;
                end
                ST_WRITE: begin
                    state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!strb_low) begin
                        relcnt <= '0;
                        state  <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (strb_low)                relcnt <= '0;
                    else if (relcnt == REL_LAST) state  <= ST_IDLE;
                    else                         relcnt <= relcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // address and write data are captured on the qualifying sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (arm && qual_done) begin
            addr_q  <= addr_s;
            wdata_q <= wdata_s;
        end
    end

    // read data is latched in the final read clock
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rdata_q <= '0;
        else if (state == ST_READ && rcnt == RD_LAST) rdata_q <= per_rdata;
    end

    // outputs are decoded from registered state only
    always_comb begin
        per_addr     = addr_q;
        per_wdata    = wdata_q;
        per_rd       = (state == ST_READ);
        per_wr       = (state == ST_WRITE);
        bus_ack      = (state == ST_HOLD);
        bus_rdata_oe = (state == ST_HOLD) && !is_wr;
        bus_rdata    = rdata_q;
    end

    // R3: a read keeps going until its count is used up, whatever the strobe
    a_r3_read_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && rcnt != RD_LAST) |=> (state == ST_READ));

    // R4: read data does not move while it is being driven
    a_r4_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_oe && $past(bus_rdata_oe)) |-> $stable(bus_rdata));

    // R5: the write pulse lasts a single clock
    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> !per_wr);

    // R6: a released strobe seen in the acknowledge state drops ack next clock
    a_r6_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !strb_low) |=> !bus_ack);

    // R7: a new access can start only from the armed states
    a_r7_access_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rd || per_wr) |-> ($past(state) == ST_IDLE || $past(state) == ST_QUAL));

    // R7: the release window is left only after a high strobe sample
    a_r7_release_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && strb_low) |=> (state == ST_RELEASE));

endmodule

// File: rtl/vme_strobe_bridge.sv
// Module: vme_strobe_bridge (top)
// Bridges an asynchronous strobe-timed bus slave to a synchronous peripheral
// register port. A synchronizer feeds a strobe qualifier and an access
// sequencer.
// Assumes: the local clock is fast enough that QUAL_CYC samples span the
// minimum legal strobe width. Bus fields are stable while the strobe is low.
module vme_strobe_bridge #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int SYNC_STG = 2,
    parameter int QUAL_CYC = 10,
    parameter int RD_CYC   = 4,
    parameter int REL_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_strb_n,
    input  logic          bus_wr_n,
    input  logic          bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    output logic          bus_ack,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic          per_wr,
    output logic          per_rd,
    input  logic [DW-1:0] per_rdata
);

    localparam int SW = 3 + AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, {(AW + DW){1'b0}}};

    logic [SW-1:0] raw_vec;
    logic [SW-1:0] syn_vec;
    logic          strb_n_s;
    logic          wr_n_s;
    logic          sel_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] wdata_s;
    logic          qual_low;
    logic          qual_done;
    logic          arm;

    // pack the asynchronous lines into one vector for synchronization
    assign raw_vec = {bus_strb_n, bus_wr_n, bus_sel, bus_addr, bus_wdata};

    vsb_sync #(
        .W       (SW),
        .STAGES  (SYNC_STG),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (syn_vec)
    );

    // unpack the synchronized fields
    assign {strb_n_s, wr_n_s, sel_s, addr_s, wdata_s} = syn_vec;

    // a sample counts toward qualification only when the address matches
    assign qual_low = !strb_n_s && sel_s;

    vsb_qualify #(
        .QUAL_CYC (QUAL_CYC)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .low   (qual_low),
        .done  (qual_done)
    );

    vsb_seq #(
        .AW      (AW),
        .DW      (DW),
        .RD_CYC  (RD_CYC),
        .REL_CYC (REL_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .strb_low     (!strb_n_s),
        .wr_sel       (!wr_n_s),
        .qual_done    (qual_done),
        .qual_low     (qual_low),
        .addr_s       (addr_s),
        .wdata_s      (wdata_s),
        .per_rdata    (per_rdata),
        .arm          (arm),
        .per_addr     (per_addr),
        .per_wdata    (per_wdata),
        .per_wr       (per_wr),
        .per_rd       (per_rd),
        .bus_ack      (bus_ack),
        .bus_rdata_oe (bus_rdata_oe),
        .bus_rdata    (bus_rdata)
    );

    // R9: with the match flag low nothing is acknowledged from idle
    a_r9_no_ack_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !sel_s) |=> !(per_rd || per_wr));

    // R1: immediately after reset no output is active
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(bus_ack || bus_rdata_oe || per_rd || per_wr));

endmodule

// File: tb/vme_strobe_bridge_tb.sv
`timescale 1ns/1ps
module vme_strobe_bridge_tb;

    localparam int AW = 16, DW = 16, QUAL = 10, RD = 4, REL = 2;
    localparam int SAFE_GAP = RD + REL + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_strb_n = 1'b1, bus_wr_n = 1'b1, bus_sel = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata, per_wdata, per_rdata;
    logic [AW-1:0] per_addr;
    logic          bus_rdata_oe, bus_ack, per_wr, per_rd;

    int checks = 0, fails = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, rd_run = 0;
    bit finished = 0;
    logic [AW-1:0] last_wr_addr;
    logic [DW-1:0] last_wr_data;
    logic [DW-1:0] exp_rdata = '0;
    logic [DW-1:0] pmem [16];
    logic [DW-1:0] ref_mem [16];
    logic prev_rd = 1'b0, prev_wr = 1'b0;

    always #2.5 clk = ~clk;

    vme_strobe_bridge #(.AW(AW), .DW(DW), .QUAL_CYC(QUAL), .RD_CYC(RD), .REL_CYC(REL)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_strb_n(bus_strb_n), .bus_wr_n(bus_wr_n),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_ack(bus_ack),
        .per_addr(per_addr), .per_wdata(per_wdata), .per_wr(per_wr),
        .per_rd(per_rd), .per_rdata(per_rdata));

    // peripheral register model
    assign per_rdata = pmem[per_addr[3:0]];
    always @(posedge clk) if (per_wr) pmem[per_addr[3:0]] <= per_wdata;

    task automatic chk(string req, logic ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pulse counts, read length, write length, driven data
    always @(negedge clk) begin
        if (rst_n) begin
            if (per_rd && !prev_rd) begin rd_cnt++; rd_run = 1; end
            else if (per_rd) rd_run++;
            else if (prev_rd) chk("R3 read length", rd_run == RD, rd_run, RD);
            if (per_wr && !prev_wr) begin
                wr_cnt++; last_wr_addr = per_addr; last_wr_data = per_wdata;
            end
            if (per_wr && prev_wr) chk("R5 write pulse width", 1'b0, 2, 1);
            if (bus_rdata_oe) chk("R4 driven read data", bus_rdata == exp_rdata, bus_rdata, exp_rdata);
            if (bus_rdata_oe && !bus_ack) chk("R4 oe without ack", 1'b0, 1, 0);
        end
        prev_rd = per_rd;
        prev_wr = per_wr;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // one bus cycle: strobe low for low_len clocks, then high for gap clocks
    task automatic bus_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit sel, input int low_len, input int gap, input string req);
        bit accept;
        int rd0, wr0;
        accept = sel && (low_len >= QUAL);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        exp_rdata = ref_mem[a[3:0]];
        bus_addr = a; bus_wdata = d; bus_wr_n = ~wr; bus_sel = sel;
        bus_strb_n = 1'b0;
        repeat (low_len) @(negedge clk);
        bus_strb_n = 1'b1;
        repeat (gap) @(negedge clk);
        chk({req, " reads"}, (rd_cnt - rd0) == int'(accept && !wr), rd_cnt - rd0, int'(accept && !wr));
        chk({req, " writes"}, (wr_cnt - wr0) == int'(accept && wr), wr_cnt - wr0, int'(accept && wr));
        if (accept && wr) begin
            chk("R5 write address", last_wr_addr == a, last_wr_addr, a);
            chk("R5 write data", last_wr_data == d, last_wr_data, d);
            ref_mem[a[3:0]] = d;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) begin pmem[i] = '0; ref_mem[i] = '0; end
        repeat (4) @(negedge clk);
        chk("R1 ack in reset", bus_ack == 1'b0, bus_ack, 0);
        chk("R1 oe in reset", bus_rdata_oe == 1'b0, bus_rdata_oe, 0);
        chk("R1 per strobes in reset", (per_rd | per_wr) == 1'b0, {per_rd, per_wr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10, R5: write then read back with a long strobe
        bus_cycle(1'b1, 16'h0003, 16'hBEEF, 1'b1, QUAL + 4, SAFE_GAP, "R10 write dir");
        bus_cycle(1'b0, 16'h0003, 16'h0000, 1'b1, QUAL + RD + 6, SAFE_GAP, "R10 read dir");

        // R2: threshold minus one is dropped, exact threshold is accepted
        bus_cycle(1'b0, 16'h0003, 16'h0, 1'b1, QUAL - 1, SAFE_GAP, "R2 short strobe");
        bus_cycle(1'b1, 16'h0005, 16'h1234, 1'b1, QUAL, SAFE_GAP, "R2 exact threshold");

        // R3: strobe released before the read completes; the read still runs full length
        bus_cycle(1'b0, 16'h0005, 16'h0, 1'b1, QUAL, SAFE_GAP, "R3 early release");

        // R6, R4: hold, stable data, ack timing after release
        exp_rdata = ref_mem[5];
        bus_addr = 16'h0005; bus_wr_n = 1'b1; bus_sel = 1'b1; bus_strb_n = 1'b0;
        repeat (QUAL + RD + 4) @(negedge clk);
        chk("R6 ack while held", bus_ack == 1'b1, bus_ack, 1);
        chk("R4 oe while held", bus_rdata_oe == 1'b1, bus_rdata_oe, 1);
        repeat (5) @(negedge clk);
        chk("R4 data kept", bus_rdata == 16'h1234, bus_rdata, 16'h1234);
        bus_strb_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 ack before detection", bus_ack == 1'b1, bus_ack, 1);
        @(negedge clk);
        chk("R6 ack dropped", bus_ack == 1'b0, bus_ack, 0);
        chk("R6 oe dropped", bus_rdata_oe == 1'b0, bus_rdata_oe, 0);
        repeat (SAFE_GAP) @(negedge clk);

        // R7: very long strobe gives one access only
        bus_cycle(1'b0, 16'h0003, 16'h0, 1'b1, 80, SAFE_GAP, "R7 long strobe");

        // R8: short glitch right after a write is ignored
        bus_cycle(1'b1, 16'h0007, 16'hCAFE, 1'b1, QUAL + 3, 3, "R8 write before glitch");
        bus_cycle(1'b0, 16'h0007, 16'h0, 1'b1, QUAL - 1, SAFE_GAP, "R8 glitch after write");
        bus_cycle(1'b0, 16'h0007, 16'h0, 1'b1, QUAL + RD + 3, SAFE_GAP, "R8 read back");

        // R9: address not matched
        bus_cycle(1'b1, 16'h0007, 16'h0BAD, 1'b0, 60, SAFE_GAP, "R9 unselected write");
        chk("R9 no ack", bus_ack == 1'b0, bus_ack, 0);
        bus_cycle(1'b0, 16'h0007, 16'h0, 1'b1, QUAL + RD + 3, SAFE_GAP, "R9 data untouched");

        // random mix around the threshold (R2, R3, R5, R10)
        for (int n = 0; n < 300; n++) begin
            bit wr = 1'($urandom_range(0, 1));
            bit sel = ($urandom_range(0, 7) != 0);
            int len = $urandom_range(1, QUAL + RD + 20);
            int gap = SAFE_GAP + $urandom_range(0, 5);
            bus_cycle(wr, AW'($urandom), DW'($urandom), sel, len, gap, "R2 random cycle");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule